// File: doc/BRIEF.md
# Signed Decade Result Accumulator with Display Latch

This block holds the running result of a multi-phase integrating conversion. A sequencer pulses a count enable, names a decade (units, tens, hundreds, ...) and a direction, and the block adds or removes one unit of that decade's weight in a sign-magnitude BCD register. Because the magnitude can pass through zero, the sign flips whenever a step toward zero overshoots it.

A conversion has two passes. In the measuring pass the counts arrive with their true sense. In the offset pass, taken with the inputs shorted, the sequencer raises the pass marker and the block inverts the sense of every step. At the end of both passes the register therefore holds the measurement minus the offset, with no separate subtraction step. A latch strobe then moves the top decades into the display latch, together with the sign and the range flags, and clears the register for the next conversion. The lowest decade is guard resolution and is never shown. A three-state hold control sets how the latch behaves: it updates on the strobe, it freezes the last reading, or it passes the live register straight to the outputs. A status output falls for one cycle each time the latch takes a new reading.

Top module: `decade_result_accum`

## Requirements
- R1: After reset the displayed digits are all zero, the sign is positive, the under-range flag is 1, the over-range flag is 0 and the status output `eocN` is 1.
- R2: A count step with `cntUp`=1 during the measuring pass adds 10^k to the magnitude, where k = `decSel` and decade 0 is the least significant digit. The BCD carry propagates through every higher decade. Every digit of the register stays in the range 0..9.
- R3: A count step with `cntUp`=0 during the measuring pass subtracts 10^k. The BCD borrow propagates through the higher decades.
- R4: If a step toward zero is larger than the current magnitude, the magnitude becomes the absolute value of the signed result and the sign flips (`dispNeg`=1 means negative).
- R5: While `passOffset`=1, every step has the opposite sense to `cntUp`. After both passes the register therefore holds the measurement minus the offset.
- R6: A `latchStb` pulse copies decades NUM_DEC-1 down to GUARD of the register to `dispDigits`, with the most significant digit in the top nibble, and copies the sign to `dispNeg`. In the same cycle it clears the register to positive zero. A count enable that arrives in the strobe cycle is ignored.
- R7: `overRange` is 1 exactly when the displayed magnitude exceeds 19999, which is when the top displayed digit is 2 or more.
- R8: `underRange` is 1 exactly when the displayed magnitude is below 1000, which is when the top two displayed digits are both zero.
- R9: With `holdMode`=00 (float), the displayed digits, sign and both flags change only on an accepted strobe.
- R10: With `holdMode`=01 (hold), a strobe leaves the digits, sign and flags unchanged and `eocN` stays 1. The strobe still clears the register.
- R11: With `holdMode`=10 (live), the digits, sign and flags follow the live register in the cycle after each step, without any strobe.
- R12: An accepted strobe drives `eocN` low for exactly the one cycle in which the new reading first appears at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Take one count step this cycle |
| cntUp | input | 1 | Step direction as seen by the sequencer (1 = up) |
| decSel | input | SEL_W (3) | Decade that receives the step |
| passOffset | input | 1 | 1 during the offset pass (inverts the step sense) |
| latchStb | input | 1 | End-of-conversion strobe: latch the reading, clear the register |
| holdMode | input | 2 | 00 float, 01 hold, 10 live, 11 treated as float |
| dispDigits | output | DISP_DEC*4 (20) | Displayed BCD digits, most significant digit in the top nibble |
| dispNeg | output | 1 | Displayed sign, 1 = negative |
| overRange | output | 1 | Displayed magnitude above 19999 |
| underRange | output | 1 | Displayed magnitude below 1000 |
| eocN | output | 1 | Falls for one cycle when the display latch updates |

## Verification
The bench builds the block with its defaults: six decades, of which one is a guard decade, giving a five-digit display. With these values every boundary is reachable in a few dozen steps. The bench crosses 19999/20000 at the top decade and 999/1000 at the under-range threshold, and it drives a carry chain through four decades. Stepping by decade weight instead of by units also lets the bench test a zero crossing in which the step is larger than the whole magnitude, and an offset pass with either sense.

// File: rtl/decade_result_pkg.sv
package decade_result_pkg;

  typedef enum logic [1:0] {
    HOLD_FLOAT  = 2'b00,
    HOLD_FREEZE = 2'b01,
    HOLD_LIVE   = 2'b10
  } holdMode_t;

  typedef struct packed {
    logic step;     // apply one weighted count
    logic up;       // effective sense after pass inversion
    logic capture;  // load display latch
    logic clear;    // zero the accumulator
  } ctlStrobes_t;

endpackage

// File: rtl/decade_result_ctrl.sv
module decade_result_ctrl
  import decade_result_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntEn,
  input  logic        cntUp,
  input  logic        passOffset,
  input  logic        latchStb,
  input  logic [1:0]  holdMode,
  output ctlStrobes_t strb,
  output logic        transparent,
  output logic        eocN
);

  logic freeze;

  always_comb begin
    freeze       = (holdMode == HOLD_FREEZE);
    transparent  = (holdMode == HOLD_LIVE);
    strb.clear   = latchStb;
    strb.capture = latchStb && !freeze;
    strb.step    = cntEn && !latchStb;
    strb.up      = cntUp ^ passOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) eocN <= 1'b1;
    else       eocN <= !strb.capture;
  end

  // R12: a falling status edge only ever follows a strobe
  p_eoc_after_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> $past(latchStb));

  // R10: a strobe while frozen never produces the status edge
  p_freeze_no_eoc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && holdMode == HOLD_FREEZE) |=> eocN);

  // R12: the status pulse is a single cycle
  p_eoc_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!eocN && !$past(latchStb && holdMode != HOLD_FREEZE)) |-> 1'b0);

endmodule

// File: rtl/decade_result_dp.sv
module decade_result_dp
  import decade_result_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int GUARD   = 1,
  localparam int W        = NUM_DEC * 4,
  localparam int DISP_DEC = NUM_DEC - GUARD,
  localparam int DW       = DISP_DEC * 4,
  localparam int SEL_W    = $clog2(NUM_DEC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              transparent,
  input  logic [SEL_W-1:0]  decSel,
  output logic [DW-1:0]     dispDigits,
  output logic              dispNeg,
  output logic              overRange,
  output logic              underRange
);

  function automatic logic [W-1:0] bcdAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic [4:0]   s;
    logic         c;
    c = 1'b0;
    r = '0;
    for (int i = 0; i < NUM_DEC; i++) begin
      s = {1'b0, a[i*4 +: 4]} + {1'b0, b[i*4 +: 4]} + {4'b0, c};
      if (s > 5'd9) begin s = s + 5'd6; c = 1'b1; end
      else c = 1'b0;
      r[i*4 +: 4] = s[3:0];
    end
    return r;
  endfunction

  // returns {borrowOut, a - b}
  function automatic logic [W:0] bcdSub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic [4:0]   d;
    logic         br;
    br = 1'b0;
    r  = '0;
    for (int i = 0; i < NUM_DEC; i++) begin
      d = {1'b0, a[i*4 +: 4]} - {1'b0, b[i*4 +: 4]} - {4'b0, br};
      if (d[4]) begin d = d + 5'd10; br = 1'b1; end
      else br = 1'b0;
      r[i*4 +: 4] = d[3:0];
    end
    return {br, r};
  endfunction

  function automatic logic allBcd(input logic [W-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DEC; i++) if (a[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic overOf(input logic [DW-1:0] d);
    return d[DW-1 -: 4] >= 4'd2;
  endfunction

  function automatic logic underOf(input logic [DW-1:0] d);
    return d[DW-1 -: 8] == 8'd0;
  endfunction

  logic [W-1:0]  magQ, magD, weight, sumV, fwdDiff, revDiff;
  logic [W:0]    fwdSub, revSub;
  logic          negQ, negD, towardZero;
  logic [DW-1:0] latDigits, liveDigits;
  logic          latNeg, latOver, latUnder;

  always_comb begin
    for (int i = 0; i < NUM_DEC; i++)
      weight[i*4 +: 4] = (decSel == SEL_W'(i)) ? 4'd1 : 4'd0;
    sumV       = bcdAdd(magQ, weight);
    fwdSub     = bcdSub(magQ, weight);
    revSub     = bcdSub(weight, magQ);
    fwdDiff    = fwdSub[W-1:0];
    revDiff    = revSub[W-1:0];
    towardZero = strb.up ? negQ : !negQ;
    magD = magQ;
    negD = negQ;
    if (strb.clear) begin
      magD = '0;
      negD = 1'b0;
    end else if (strb.step) begin
      if (!towardZero)      magD = sumV;
      else if (!fwdSub[W])  magD = fwdDiff;
      else begin
        magD = revDiff;
        negD = !negQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      magQ <= '0;
      negQ <= 1'b0;
    end else begin
      magQ <= magD;
      negQ <= negD;
    end
  end

  assign liveDigits = magQ[W-1 : GUARD*4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latDigits <= '0;
      latNeg    <= 1'b0;
      latOver   <= 1'b0;
      latUnder  <= 1'b1;
    end else if (strb.capture) begin
      latDigits <= liveDigits;
      latNeg    <= negQ;
      latOver   <= overOf(liveDigits);
      latUnder  <= underOf(liveDigits);
    end
  end

  always_comb begin
    if (transparent) begin
      dispDigits = liveDigits;
      dispNeg    = negQ;
      overRange  = overOf(liveDigits);
      underRange = underOf(liveDigits);
    end else begin
      dispDigits = latDigits;
      dispNeg    = latNeg;
      overRange  = latOver;
      underRange = latUnder;
    end
  end

  // R2: every decade of the accumulator remains a legal BCD digit
  p_digits_bcd_r2: assert property (@(posedge clk) disable iff (!rstN)
    allBcd(magQ));

  // R6: the end-of-conversion strobe leaves a positive zero behind
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (magQ == '0 && !negQ));

  // R9: latched reading and flags only move on a capture
  p_latch_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(latDigits) && $stable(latNeg) &&
                       $stable(latOver) && $stable(latUnder)));

  // R7: latched over-range agrees with the latched top digit
  p_over_consistent_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (latOver == (latDigits[DW-1 -: 4] >= 4'd2)));

  // R4: an idle cycle leaves the sign untouched
  p_sign_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.clear) |=> $stable(negQ));

endmodule

// File: rtl/decade_result_accum.sv
module decade_result_accum
  import decade_result_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int GUARD   = 1,
  localparam int DISP_DEC = NUM_DEC - GUARD,
  localparam int DW       = DISP_DEC * 4,
  localparam int SEL_W    = $clog2(NUM_DEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             cntUp,
  input  logic [SEL_W-1:0] decSel,
  input  logic             passOffset,
  input  logic             latchStb,
  input  logic [1:0]       holdMode,
  output logic [DW-1:0]    dispDigits,
  output logic             dispNeg,
  output logic             overRange,
  output logic             underRange,
  output logic             eocN
);

  ctlStrobes_t strb;
  logic        transparent;

  decade_result_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cntEn       (cntEn),
    .cntUp       (cntUp),
    .passOffset  (passOffset),
    .latchStb    (latchStb),
    .holdMode    (holdMode),
    .strb        (strb),
    .transparent (transparent),
    .eocN        (eocN)
  );

  decade_result_dp #(.NUM_DEC(NUM_DEC), .GUARD(GUARD)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .transparent (transparent),
    .decSel      (decSel),
    .dispDigits  (dispDigits),
    .dispNeg     (dispNeg),
    .overRange   (overRange),
    .underRange  (underRange)
  );

endmodule

// File: tb/decade_result_accum_tb_top.sv
`timescale 1ns/1ps
module decade_result_accum_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0, cntUp = 1'b0, passOffset = 1'b0, latchStb = 1'b0;
  logic [2:0]  decSel = '0;
  logic [1:0]  holdMode = 2'b00;
  logic [19:0] dispDigits;
  logic        dispNeg, overRange, underRange, eocN;

  int checks = 0;
  int failures = 0;
  int model = 0;
  int eocLowSeen = 0;

  always #10 clk = ~clk;

  decade_result_accum dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .cntUp(cntUp), .decSel(decSel),
    .passOffset(passOffset), .latchStb(latchStb), .holdMode(holdMode),
    .dispDigits(dispDigits), .dispNeg(dispNeg), .overRange(overRange),
    .underRange(underRange), .eocN(eocN)
  );

  always @(negedge clk) if (rstN && !eocN) eocLowSeen++;

  function automatic logic [19:0] toBcd(input int v);
    logic [19:0] r;
    int t;
    t = v;
    for (int i = 0; i < 5; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkReading(input string req, input int val);
    int mag, shown;
    mag   = (val < 0) ? -val : val;
    shown = mag / 10;
    check({req, " digits"}, 32'(dispDigits), 32'(toBcd(shown)));
    if (shown != 0) check({req, " sign"}, 32'(dispNeg), 32'(val < 0));
    check({req, " over"},  32'(overRange),  32'(shown > 19999));
    check({req, " under"}, 32'(underRange), 32'(shown < 1000));
  endtask

  task automatic step(input int dec, input logic up, input int n);
    int w;
    w = 1;
    for (int i = 0; i < dec; i++) w = w * 10;
    @(negedge clk);
    decSel = 3'(dec); cntUp = up; cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
    model = model + (((up ^ passOffset) != 0) ? n * w : -n * w);
  endtask

  // one strobe cycle; returns at the negedge after the updating edge
  int lastShown;
  task automatic strobe();
    @(negedge clk);
    latchStb = 1'b1;
    @(negedge clk);
    latchStb = 1'b0;
    lastShown = model;
    model = 0;
  endtask

  task automatic t_reset();
    check("R1 digits", 32'(dispDigits), 0);
    check("R1 sign", 32'(dispNeg), 0);
    check("R1 under", 32'(underRange), 1);
    check("R1 over", 32'(overRange), 0);
    check("R1 eocN", 32'(eocN), 1);
  endtask

  task automatic t_carry();
    step(4, 1, 1); step(3, 1, 9); step(2, 1, 9); step(1, 1, 9);
    step(1, 1, 1);                       // 19990 + 10 ripples to 20000
    strobe();
    checkReading("R2 R6 carry", lastShown);
    check("R12 eocN low", 32'(eocN), 0);
    @(negedge clk);
    check("R12 eocN back", 32'(eocN), 1);
  endtask

  task automatic t_borrow();
    step(3, 1, 1); step(0, 0, 1);        // 1000 - 1 = 999
    strobe();
    checkReading("R3 R8 borrow", lastShown);
  endtask

  task automatic t_signFlip();
    step(1, 1, 3); step(2, 0, 1);        // 30 - 100 = -70
    strobe();
    checkReading("R4 flip", lastShown);
    check("R4 negative", 32'(dispNeg), 1);
    step(2, 0, 2); step(3, 1, 1);        // -200 + 1000 = 800
    strobe();
    checkReading("R4 flip back", lastShown);
  endtask

  task automatic t_offset();
    step(3, 1, 3); step(0, 1, 7);        // 3007 measured
    passOffset = 1'b1;
    step(1, 1, 2);                       // offset +20 is removed
    step(0, 0, 3);                       // offset -3 is added back
    passOffset = 1'b0;
    strobe();
    checkReading("R5 offset", lastShown);
  endtask

  task automatic t_range();
    step(5, 1, 1); step(4, 1, 9); step(3, 1, 9); step(2, 1, 9); step(1, 1, 9);
    strobe();
    checkReading("R7 at 19999", lastShown);
    step(5, 1, 2);
    strobe();
    checkReading("R7 over", lastShown);
    step(4, 1, 1);
    strobe();
    checkReading("R8 at 1000", lastShown);
  endtask

  task automatic t_stable();
    step(3, 1, 5);
    strobe();
    step(5, 1, 3); step(0, 0, 4);
    checkReading("R9 stable", lastShown);
    strobe();
  endtask

  task automatic t_hold();
    int keep;
    step(2, 1, 4); step(4, 1, 1);        // 10400
    strobe();
    keep = lastShown;
    holdMode = 2'b01;
    step(5, 1, 3);
    eocLowSeen = 0;
    strobe();
    @(negedge clk);
    checkReading("R10 frozen", keep);
    check("R10 no eoc", 32'(eocLowSeen), 0);
    holdMode = 2'b00;
    strobe();
    check("R10 cleared digits", 32'(dispDigits), 0);
    check("R10 cleared under", 32'(underRange), 1);
  endtask

  task automatic t_live();
    holdMode = 2'b10;
    step(4, 1, 2);
    checkReading("R11 live a", model);
    step(5, 1, 2);
    checkReading("R11 live b", model);
    step(5, 0, 3); step(4, 0, 2);
    checkReading("R11 live neg", model);
    holdMode = 2'b00;
    strobe();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry();
    t_borrow();
    t_signFlip();
    t_offset();
    t_range();
    t_stable();
    t_hold();
    t_live();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule